// File: doc/BRIEF.md
# Over-Temperature Alert with Fault Queue

This block watches a stream of temperature readings and raises an alert line when a reading crosses a programmable upper limit. It releases the line according to the selected mode. Each reading comes with a one-cycle valid strobe and an 11-bit signed value in quarter-degree steps. Only the nine upper bits, in half-degree steps, are compared against two signed 9-bit limits: an upper trip point and a lower release point.

Two behaviours are available. As a thermostat, the alert follows the temperature with hysteresis. As a latched event source, the alert holds until any register read acknowledges it, and the next event is the opposite crossing. Glitch rejection comes from a consecutive-fault counter: the alert changes state only after a programmed run of qualifying readings. The active level of the alert pin is programmable. A halt input models the converter being stopped. While it is high, readings are ignored, and in latched mode a pending alert is dropped.

Top module: `thermAlert`

## Requirements
- R1: After reset the alert is inactive, the fault count is zero, and the first latched-mode event is an upper crossing.
- R2: Comparison uses `sampleTemp[10:2]` as a signed value. The upper condition is strictly greater than `limitHigh`, and the lower condition is strictly less than `limitLow`, both compared as signed.
- R3: In thermostat mode (`cfgLatchMode`=0), an inactive alert becomes active and an active alert becomes inactive on the clock edge that accepts the reading completing the queue. Activation needs readings above the upper limit, and release needs readings below the lower limit.
- R4: In thermostat mode, `regRead` and `cfgHalt` never change the alert.
- R5: `queueSel` sets the run length: 00 gives 1, 01 gives 2, 10 gives 4 and 11 gives 6 consecutive qualifying readings.
- R6: Any accepted reading that does not meet the condition currently watched clears the run. The run also clears whenever the alert changes state.
- R7: In latched mode (`cfgLatchMode`=1), the alert fires on a completed run of upper crossings and holds until a cycle with `regRead`=1. The next event is then a run of lower crossings, and the two kinds alternate from there.
- R8: In latched mode, `cfgHalt`=1 clears an active alert.
- R9: Readings that arrive while `cfgHalt`=1 are ignored in both modes.
- R10: `alertPin` equals the alert state when `cfgActiveHigh`=1 and its inverse when `cfgActiveHigh`=0.
- R11: In latched mode, readings that arrive while the alert is held are not counted toward the next run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sampleValid | input | 1 | One-cycle strobe marking a finished conversion |
| sampleTemp | input | 11 | Signed temperature, quarter-degree steps |
| limitHigh | input | 9 | Signed upper trip point, half-degree steps |
| limitLow | input | 9 | Signed lower release point, half-degree steps |
| queueSel | input | 2 | Run-length code |
| cfgActiveHigh | input | 1 | Alert pin active level (0 = active low) |
| cfgLatchMode | input | 1 | 0 = thermostat, 1 = latched events |
| cfgHalt | input | 1 | Converter stopped |
| regRead | input | 1 | One-cycle strobe for any register read |
| alertPin | output | 1 | Alert level before the open-drain driver |

## Verification
The assertions assume that the mode bit changes only while the block is in reset. They also assume that `limitHigh` is above `limitLow`, because equal or inverted limits give no defined behaviour. The stimulus keeps to both assumptions: it switches mode only around a reset and uses ordered limits, including a negative pair. Limits and run length change only between readings, never in the cycle a reading is accepted.

// File: rtl/thermAlertPkg.sv
package thermAlertPkg;
  // strobes from control to the fault-run datapath
  typedef struct packed {
    logic bump;   // count one more qualifying reading
    logic clear;  // restart the run
  } cntCtl_t;

  // which crossing the latched mode waits for next
  typedef enum logic {
    ARM_HIGH = 1'b0,
    ARM_LOW  = 1'b1
  } arm_e;

  localparam int MAX_QUEUE = 6;
endpackage

// File: rtl/thermAlertDp.sv
module thermAlertDp
  import thermAlertPkg::*;
#(
  parameter int TEMP_W = 11,
  parameter int LIM_W  = 9,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TEMP_W-1:0] sampleTemp,
  input  logic [LIM_W-1:0]  limitHigh,
  input  logic [LIM_W-1:0]  limitLow,
  input  logic [1:0]        queueSel,
  input  cntCtl_t           cntCtl,
  output logic              overHigh,
  output logic              underLow,
  output logic              queueFull
);
  localparam int DROP = TEMP_W - LIM_W;

  logic signed [LIM_W-1:0] tempCoarse;
  logic [CNT_W-1:0]        faultCount;
  logic [CNT_W-1:0]        queueTarget;
  logic                    unusedFraction;

  assign tempCoarse     = sampleTemp[TEMP_W-1 -: LIM_W];
  assign unusedFraction = ^sampleTemp[DROP-1:0];

  assign overHigh = tempCoarse > $signed(limitHigh);
  assign underLow = tempCoarse < $signed(limitLow);

  function automatic logic [CNT_W-1:0] queueDepth(input logic [1:0] sel);
    case (sel)
      2'b00:   return CNT_W'(1);
      2'b01:   return CNT_W'(2);
      2'b10:   return CNT_W'(4);
      default: return CNT_W'(MAX_QUEUE);
    endcase
  endfunction

  assign queueTarget = queueDepth(queueSel);
  // true when one more qualifying reading completes the run
  assign queueFull = ({1'b0, faultCount} + (CNT_W+1)'(1)) >= {1'b0, queueTarget};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             faultCount <= '0;
    else if (cntCtl.clear) faultCount <= '0;
    else if (cntCtl.bump)  faultCount <= faultCount + CNT_W'(1);
  end

  // R6: the run never reaches the longest queue without firing
  a_r6_count_bounded: assert property (@(posedge clk) disable iff (!rstN)
    faultCount < CNT_W'(MAX_QUEUE));

  // R6: a clear strobe from control empties the run
  a_r6_clear_empties: assert property (@(posedge clk) disable iff (!rstN)
    cntCtl.clear |=> faultCount == '0);
endmodule

// File: rtl/thermAlertCtl.sv
module thermAlertCtl
  import thermAlertPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    sampleValid,
  input  logic    cfgLatchMode,
  input  logic    cfgHalt,
  input  logic    regRead,
  input  logic    overHigh,
  input  logic    underLow,
  input  logic    queueFull,
  output cntCtl_t cntCtl,
  output logic    alertActive
);
  arm_e armState;
  logic watchLow;
  logic sampleOk;
  logic tripCond;
  logic fire;
  logic ackClear;

  // thermostat watches the release crossing while active;
  // latched mode follows the alternating arm state
  assign watchLow = cfgLatchMode ? (armState == ARM_LOW) : alertActive;
  assign sampleOk = sampleValid && !cfgHalt && !(cfgLatchMode && alertActive);
  assign tripCond = watchLow ? underLow : overHigh;
  assign fire     = sampleOk && tripCond && queueFull;
  assign ackClear = cfgLatchMode && alertActive && (regRead || cfgHalt);

  always_comb begin
    cntCtl.bump  = sampleOk && tripCond && !queueFull;
    cntCtl.clear = (sampleOk && !tripCond) || fire || ackClear;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      alertActive <= 1'b0;
      armState    <= ARM_HIGH;
    end else if (fire) begin
      if (cfgLatchMode) begin
        alertActive <= 1'b1;
        armState    <= (armState == ARM_HIGH) ? ARM_LOW : ARM_HIGH;
      end else begin
        alertActive <= !alertActive;
      end
    end else if (ackClear) begin
      alertActive <= 1'b0;
    end
  end

  // R4: thermostat alert moves only on an accepted reading
  a_r4_cmp_steady: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgLatchMode && !(sampleValid && !cfgHalt)) |=> $stable(alertActive));

  // R7: a held event stays until acknowledged
  a_r7_latch_hold: assert property (@(posedge clk) disable iff (!rstN)
    (cfgLatchMode && alertActive && !regRead && !cfgHalt) |=> alertActive);

  // R7: a register read acknowledges a held event
  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (cfgLatchMode && alertActive && regRead) |=> !alertActive);

  // R8: halting in latched mode drops the alert
  a_r8_halt_clears: assert property (@(posedge clk) disable iff (!rstN)
    (cfgLatchMode && cfgHalt) |=> !alertActive);
endmodule

// File: rtl/thermAlert.sv
module thermAlert
  import thermAlertPkg::*;
#(
  parameter int TEMP_W = 11,
  parameter int LIM_W  = 9,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleValid,
  input  logic [TEMP_W-1:0] sampleTemp,
  input  logic [LIM_W-1:0]  limitHigh,
  input  logic [LIM_W-1:0]  limitLow,
  input  logic [1:0]        queueSel,
  input  logic              cfgActiveHigh,
  input  logic              cfgLatchMode,
  input  logic              cfgHalt,
  input  logic              regRead,
  output logic              alertPin
);
  cntCtl_t cntCtl;
  logic    overHigh;
  logic    underLow;
  logic    queueFull;
  logic    alertActive;

  thermAlertDp #(.TEMP_W(TEMP_W), .LIM_W(LIM_W), .CNT_W(CNT_W)) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .sampleTemp (sampleTemp),
    .limitHigh  (limitHigh),
    .limitLow   (limitLow),
    .queueSel   (queueSel),
    .cntCtl     (cntCtl),
    .overHigh   (overHigh),
    .underLow   (underLow),
    .queueFull  (queueFull)
  );

  thermAlertCtl uCtl (
    .clk          (clk),
    .rstN         (rstN),
    .sampleValid  (sampleValid),
    .cfgLatchMode (cfgLatchMode),
    .cfgHalt      (cfgHalt),
    .regRead      (regRead),
    .overHigh     (overHigh),
    .underLow     (underLow),
    .queueFull    (queueFull),
    .cntCtl       (cntCtl),
    .alertActive  (alertActive)
  );

  assign alertPin = cfgActiveHigh ? alertActive : !alertActive;
endmodule

// File: tb/tb_thermAlert.sv
module tb_thermAlert;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sampleValid = 1'b0;
  logic [10:0] sampleTemp = '0;
  logic [8:0]  limitHigh = 9'd160;
  logic [8:0]  limitLow = 9'd150;
  logic [1:0]  queueSel = 2'b00;
  logic        cfgActiveHigh = 1'b0;
  logic        cfgLatchMode = 1'b0;
  logic        cfgHalt = 1'b0;
  logic        regRead = 1'b0;
  logic        alertPin;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic  expQ[$];
  string tagQ[$];

  always #10 clk = !clk;  // 50 MHz

  thermAlert dut (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleTemp(sampleTemp),
    .limitHigh(limitHigh), .limitLow(limitLow), .queueSel(queueSel),
    .cfgActiveHigh(cfgActiveHigh), .cfgLatchMode(cfgLatchMode), .cfgHalt(cfgHalt),
    .regRead(regRead), .alertPin(alertPin)
  );

  // monitor: compare the pin after each edge against the scoreboard
  always @(posedge clk) begin
    #5;
    if (expQ.size() > 0) begin
      logic  e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      checks++;
      if (alertPin !== e) begin
        errors++;
        $display("FAIL %s: alertPin=%b expected=%b", t, alertPin, e);
      end
    end
  end

  // driver: one cycle of stimulus plus the expected pin after that edge
  task automatic step(input bit v, input int quarter, input bit rd, input bit hl,
                      input logic exp, input string tag);
    @(negedge clk);
    sampleValid = v;
    sampleTemp  = 11'(quarter);
    regRead     = rd;
    cfgHalt     = hl;
    expQ.push_back(exp);
    tagQ.push_back(tag);
    @(posedge clk);
    #6;
    sampleValid = 1'b0;
    regRead     = 1'b0;
  endtask

  task automatic doReset(input bit latch);
    @(negedge clk);
    rstN = 1'b0;
    cfgLatchMode = latch;
    cfgHalt = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    checks++;
    if (alertPin !== 1'b1) begin
      errors++;
      $display("FAIL R1: alertPin=%b expected=1", alertPin);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finishRun();
  end

  initial begin
    // ---- thermostat mode, run length 1, active low ----
    doReset(1'b0);
    step(1, 640, 0, 0, 1'b1, "R2 equal to upper limit");
    step(1, 641, 0, 0, 1'b1, "R2 fraction bits dropped");
    step(1, 644, 0, 0, 1'b0, "R3 upper crossing activates");
    step(0, 0,   1, 0, 1'b0, "R4 read ignored");
    step(1, 400, 0, 1, 1'b0, "R4 R9 halted reading ignored");
    step(1, 600, 0, 0, 1'b0, "R2 equal to lower limit");
    step(1, 596, 0, 0, 1'b1, "R3 lower crossing releases");
    // ---- run length 2 ----
    queueSel = 2'b01;
    step(1, 644, 0, 0, 1'b1, "R5 len2 first");
    step(1, 644, 0, 0, 1'b0, "R5 len2 second fires");
    step(1, 590, 0, 0, 1'b0, "R5 len2 release first");
    step(1, 620, 0, 0, 1'b0, "R6 in-band reading");
    step(1, 590, 0, 0, 1'b0, "R6 run restarted");
    step(1, 590, 0, 0, 1'b1, "R6 run completes");
    // ---- run length 4 ----
    queueSel = 2'b10;
    for (int i = 0; i < 3; i++) step(1, 644, 0, 0, 1'b1, "R5 len4 partial");
    step(1, 620, 0, 0, 1'b1, "R6 len4 broken run");
    for (int i = 0; i < 3; i++) step(1, 644, 0, 0, 1'b1, "R6 len4 restarted");
    step(1, 644, 0, 0, 1'b0, "R5 len4 fires");
    // ---- run length 6 ----
    queueSel = 2'b11;
    for (int i = 0; i < 5; i++) step(1, 590, 0, 0, 1'b0, "R5 len6 partial");
    step(1, 590, 0, 0, 1'b1, "R5 len6 fires");
    // ---- polarity ----
    queueSel = 2'b00;
    cfgActiveHigh = 1'b1;
    step(0, 0,   0, 0, 1'b0, "R10 active-high idle");
    step(1, 644, 0, 0, 1'b1, "R10 active-high asserted");
    cfgActiveHigh = 1'b0;
    step(0, 0,   0, 0, 1'b0, "R10 active-low asserted");
    // ---- negative limits, signed compare ----
    limitHigh = 9'(-10);
    limitLow  = 9'(-20);
    step(1, -84, 0, 0, 1'b1, "R2 signed below lower");
    step(1, 8,   0, 0, 1'b0, "R2 signed above negative upper");
    step(1, -80, 0, 0, 1'b0, "R2 signed equal lower");
    step(1, -84, 0, 0, 1'b1, "R3 signed release");
    limitHigh = 9'd160;
    limitLow  = 9'd150;

    // ---- latched mode ----
    doReset(1'b1);
    step(1, 596, 0, 0, 1'b1, "R1 R7 first event is upper");
    step(1, 644, 0, 0, 1'b0, "R7 upper event");
    step(1, 596, 0, 0, 1'b0, "R7 held");
    step(0, 0,   0, 0, 1'b0, "R7 held idle");
    step(0, 0,   1, 0, 1'b1, "R7 read acknowledges");
    step(1, 644, 0, 0, 1'b1, "R7 upper ignored when armed low");
    step(1, 596, 0, 0, 1'b0, "R7 lower event");
    step(0, 0,   1, 0, 1'b1, "R7 read acknowledges again");
    step(1, 596, 0, 0, 1'b1, "R7 armed upper again");
    step(1, 644, 0, 0, 1'b0, "R7 second upper event");
    step(0, 0,   0, 1, 1'b1, "R8 halt clears");
    step(1, 596, 0, 1, 1'b1, "R9 halted reading ignored");
    queueSel = 2'b01;
    step(1, 596, 0, 0, 1'b1, "R5 latched len2 first");
    step(1, 596, 0, 0, 1'b0, "R5 latched len2 fires");
    step(1, 644, 0, 0, 1'b0, "R11 reading while held");
    step(0, 0,   1, 0, 1'b1, "R11 acknowledge");
    step(1, 644, 0, 0, 1'b1, "R11 held reading not counted");
    step(1, 644, 0, 0, 1'b0, "R11 run completes");
    step(0, 0,   0, 0, 1'b0, "R7 held after run");
    @(negedge clk);
    @(negedge clk);
    finishRun();
  end
endmodule